// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Controller

This block gathers the interrupt sources of a small Ethernet MAC into one status byte and drives a single masked interrupt request. Each source latches its own event, and each has its own clear rule. Transmit-empty, receive-overrun and management-interface bits are cleared by an acknowledge write. The allocation bit is cleared by the allocation logic. The protocol-handler bit is the OR of three latched causes, each gated by an enable, and each cause clears on its own side effect: dropping the link enable, reading the statistics counter, or turning transmit back on.

Software reaches the block through a small write port that selects one of three registers: acknowledge, mask or control. A separate strobe marks a read of the statistics counter register. The packet memory manager, the counters and the PHY lie outside the block and appear only as event inputs.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset, `status`, `cause` and `irq` read 0, and the mask and all control bits are 0.
- R2: Status layout: bit 0 transmit-empty, bit 1 allocation, bit 2 receive-overrun, bit 3 protocol-handler, bit 4 management. Bits 7:5 always read 0.
- R3: The management bit sets on a `mgmt_evt` pulse and stays set until an acknowledge write (`reg_sel`=0) has `reg_wdata[4]`=1.
- R4: The receive-overrun bit sets when any of the three `rx_abort` lines is high. It clears only through an acknowledge write with `reg_wdata[2]`=1.
- R5: The transmit-empty bit sets on every clock in which `tx_fifo_empty` is high. An acknowledge write with `reg_wdata[0]`=1 clears it only if the FIFO is no longer empty, so acknowledging and then reading gives the live empty state.
- R6: The allocation bit sets on `alloc_ok` and clears on `alloc_req` or `alloc_fail`, so after a failure it reads 0. Acknowledge writes do not touch it.
- R7: The protocol-handler bit is the OR of (link cause AND control bit 0), (rollover cause AND control bit 1) and (transmit-error cause AND control bit 2). The causes latch whatever the enables are. `cause` bits: 0 link, 1 rollover, 2 transmit error, 3 transmit enable, 4 transmit success, 6:5 reason code, 7 zero.
- R8: The link cause sets on `link_evt` and clears on a control write (`reg_sel`=2) with `reg_wdata[0]`=0.
- R9: The rollover cause sets on `roll_evt` and clears on a `cnt_rd` strobe.
- R10: A `txfail_evt` sets the transmit-error cause, forces transmit enable and transmit success to 0, and stores `txfail_rsn` (0 SQE error, 1 lost carrier, 2 late collision, 3 sixteen collisions). A control write with `reg_wdata[3]`=1 clears the cause and the reason and sets transmit enable. A `tx_ok_evt` sets transmit success.
- R11: `irq` is a register equal to the OR of (status AND mask) from the previous clock. The mask is written with `reg_sel`=1.
- R12: When a source event and its clear arrive in the same clock, the bit ends up set.
- R13: Acknowledge writes never set a status bit. Zero bit positions in an acknowledge write leave their bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| rx_abort | input | 3 | Receive abort reasons: no memory, oversize frame, discard |
| mgmt_evt | input | 1 | Management interface state-change pulse |
| alloc_req | input | 1 | New transmit-page allocation request pulse |
| alloc_ok | input | 1 | Allocation succeeded pulse |
| alloc_fail | input | 1 | Allocation failed pulse |
| link_evt | input | 1 | Link test transition pulse |
| roll_evt | input | 1 | Statistics counter rollover pulse |
| tx_ok_evt | input | 1 | Frame transmitted successfully pulse |
| txfail_evt | input | 1 | Fatal transmit error pulse |
| txfail_rsn | input | 2 | Fatal transmit error reason code |
| cnt_rd | input | 1 | Statistics counter register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 acknowledge, 1 mask, 2 control, 3 none |
| reg_wdata | input | 8 | Register write data |
| status | output | 8 | Latched interrupt status byte |
| cause | output | 8 | Protocol-handler cause and transmit state |
| irq | output | 1 | Masked interrupt request |

## Verification
Every status and cause bit is a single register stage behind its inputs, so an event or clear presented before edge k shows on `status` and `cause` after edge k. `irq` has one more register and follows a status or mask change one edge later. The bench drives inputs just after a falling edge and updates its own model at the rising edge. It compares every output at the next falling edge, so each bit is checked in the cycle it is due, never early and never late.

// File: rtl/mac_irq_pkg.sv
`timescale 1ns/1ps
// mac_irq_pkg: bit positions and register selects shared by the interrupt
// status controller and its checker. Assumes an 8-bit register data path.
package mac_irq_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned RX_SRC  = 3;
    localparam int unsigned RSN_W   = 2;

    // status byte positions
    localparam int unsigned ST_TXE  = 0;
    localparam int unsigned ST_ALC  = 1;
    localparam int unsigned ST_RXO  = 2;
    localparam int unsigned ST_PHE  = 3;
    localparam int unsigned ST_MGI  = 4;
    localparam int unsigned ST_USED = 5;

    // control register positions
    localparam int unsigned CT_LINK  = 0;
    localparam int unsigned CT_ROLL  = 1;
    localparam int unsigned CT_TXERR = 2;
    localparam int unsigned CT_TXEN  = 3;

    // cause register positions
    localparam int unsigned CA_LINK  = 0;
    localparam int unsigned CA_ROLL  = 1;
    localparam int unsigned CA_TXERR = 2;
    localparam int unsigned CA_TXEN  = 3;
    localparam int unsigned CA_TXOK  = 4;
    localparam int unsigned CA_RSN   = 5;

    typedef enum logic [1:0] {
        SEL_ACK  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mac_irq_sticky.sv
`timescale 1ns/1ps
// mac_irq_sticky: a vector of set/clear latches for the software-cleared and
// allocation-cleared status bits. Assumes set and clear are one-clock
// qualified inputs. Set wins over clear in the same clock.
module mac_irq_sticky #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // hold each bit until cleared, set has priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/mac_irq_cfg.sv
`timescale 1ns/1ps
// mac_irq_cfg: holds the mask register and the control enables. Transmit
// enable is forced low by a fatal transmit error, which beats a write in the
// same clock. Assumes wr_mask and wr_ctrl are never high together.
module mac_irq_cfg
    import mac_irq_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wdata,
    input  logic         txfail_evt,
    output logic [W-1:0] mask_q,
    output logic         link_en,
    output logic         roll_en,
    output logic         txerr_en,
    output logic         tx_en
);
    // mask register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wdata;
    end

    // cause enable bits from the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_en  <= 1'b0;
            roll_en  <= 1'b0;
            txerr_en <= 1'b0;
        end else if (wr_ctrl) begin
            link_en  <= wdata[CT_LINK];
            roll_en  <= wdata[CT_ROLL];
            txerr_en <= wdata[CT_TXERR];
        end
    end

    // transmit enable, dropped by a fatal transmit error
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_en <= 1'b0;
        else if (txfail_evt)
            tx_en <= 1'b0;
        else if (wr_ctrl)
            tx_en <= wdata[CT_TXEN];
    end
endmodule

// File: rtl/mac_irq_phcause.sv
`timescale 1ns/1ps
// mac_irq_phcause: latches the three protocol-handler causes, the fatal
// transmit reason and the transmit success flag. Each cause has its own clear
// side effect. Events win over clears in the same clock.
module mac_irq_phcause
    import mac_irq_pkg::*;
#(
    parameter int unsigned RW = RSN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_evt,
    input  logic          roll_evt,
    input  logic          txfail_evt,
    input  logic [RW-1:0] txfail_rsn,
    input  logic          tx_ok_evt,
    input  logic          cnt_rd,
    input  logic          wr_ctrl,
    input  logic          wr_link_en,
    input  logic          wr_tx_en,
    output logic          link_q,
    output logic          roll_q,
    output logic          txerr_q,
    output logic [RW-1:0] rsn_q,
    output logic          txok_q
);
    logic txerr_clr;
    assign txerr_clr = wr_ctrl && wr_tx_en;

    // link cause, cleared by writing its enable to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_q <= 1'b0;
        else if (link_evt)
            link_q <= 1'b1;
        else if (wr_ctrl && !wr_link_en)
            link_q <= 1'b0;
    end

    // rollover cause, cleared by a counter register read
    always_ff @(posedge clk) begin
        if (!rst_n)
            roll_q <= 1'b0;
        else if (roll_evt)
            roll_q <= 1'b1;
        else if (cnt_rd)
            roll_q <= 1'b0;
    end

    // transmit error cause and reason, cleared by re-enabling transmit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txerr_q <= 1'b0;
            rsn_q   <= '0;
        end else if (txfail_evt) begin
            txerr_q <= 1'b1;
            rsn_q   <= txfail_rsn;
        end else if (txerr_clr) begin
            txerr_q <= 1'b0;
            rsn_q   <= '0;
        end
    end

    // transmit success flag, dropped by a fatal error
    always_ff @(posedge clk) begin
        if (!rst_n)
            txok_q <= 1'b0;
        else if (txfail_evt)
            txok_q <= 1'b0;
        else if (tx_ok_evt)
            txok_q <= 1'b1;
    end
endmodule

// File: rtl/mac_irq_ctrl.sv
`timescale 1ns/1ps
// mac_irq_ctrl: interrupt status controller of a small Ethernet MAC. It
// decodes the register write port, latches each source with its own clear
// rule, assembles the status and cause bytes and registers the masked
// request. Assumes all event inputs are synchronous one-clock pulses, except
// tx_fifo_empty, which is a level.
module mac_irq_ctrl
    import mac_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_fifo_empty,
    input  logic [RX_SRC-1:0]   rx_abort,
    input  logic                mgmt_evt,
    input  logic                alloc_req,
    input  logic                alloc_ok,
    input  logic                alloc_fail,
    input  logic                link_evt,
    input  logic                roll_evt,
    input  logic                tx_ok_evt,
    input  logic                txfail_evt,
    input  logic [RSN_W-1:0]    txfail_rsn,
    input  logic                cnt_rd,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    status,
    output logic [REG_W-1:0]    cause,
    output logic                irq
);
    localparam int unsigned NSTICKY = 4;
    localparam int unsigned K_TXE = 0;
    localparam int unsigned K_RXO = 1;
    localparam int unsigned K_MGI = 2;
    localparam int unsigned K_ALC = 3;

    logic               wr_ack, wr_mask, wr_ctrl;
    logic [NSTICKY-1:0] st_set, st_clr, st_q;
    logic [REG_W-1:0]   mask_q;
    logic               link_en, roll_en, txerr_en, tx_en;
    logic               link_q, roll_q, txerr_q, txok_q;
    logic [RSN_W-1:0]   rsn_q;
    logic               phe;
    logic               irq_q;

    // register write decode
    always_comb begin
        wr_ack  = reg_wr && (reg_sel_e'(reg_sel) == SEL_ACK);
        wr_mask = reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK);
        wr_ctrl = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
    end

    // set and clear terms of the latched sources
    always_comb begin
        st_set[K_TXE] = tx_fifo_empty;
        st_clr[K_TXE] = wr_ack && reg_wdata[ST_TXE];
        st_set[K_RXO] = |rx_abort;
        st_clr[K_RXO] = wr_ack && reg_wdata[ST_RXO];
        st_set[K_MGI] = mgmt_evt;
        st_clr[K_MGI] = wr_ack && reg_wdata[ST_MGI];
        st_set[K_ALC] = alloc_ok;
        st_clr[K_ALC] = alloc_req || alloc_fail;
    end

    mac_irq_sticky #(.N(NSTICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    mac_irq_cfg #(.W(REG_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mask    (wr_mask),
        .wr_ctrl    (wr_ctrl),
        .wdata      (reg_wdata),
        .txfail_evt (txfail_evt),
        .mask_q     (mask_q),
        .link_en    (link_en),
        .roll_en    (roll_en),
        .txerr_en   (txerr_en),
        .tx_en      (tx_en)
    );

    mac_irq_phcause #(.RW(RSN_W)) u_ph (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_evt   (link_evt),
        .roll_evt   (roll_evt),
        .txfail_evt (txfail_evt),
        .txfail_rsn (txfail_rsn),
        .tx_ok_evt  (tx_ok_evt),
        .cnt_rd     (cnt_rd),
        .wr_ctrl    (wr_ctrl),
        .wr_link_en (reg_wdata[CT_LINK]),
        .wr_tx_en   (reg_wdata[CT_TXEN]),
        .link_q     (link_q),
        .roll_q     (roll_q),
        .txerr_q    (txerr_q),
        .rsn_q      (rsn_q),
        .txok_q     (txok_q)
    );

    // protocol-handler interrupt from the enabled causes
    assign phe = (link_q & link_en) | (roll_q & roll_en) | (txerr_q & txerr_en);

    // status byte assembly, reserved bits tied low
    always_comb begin
        status         = '0;
        status[ST_TXE] = st_q[K_TXE];
        status[ST_ALC] = st_q[K_ALC];
        status[ST_RXO] = st_q[K_RXO];
        status[ST_PHE] = phe;
        status[ST_MGI] = st_q[K_MGI];
    end

    // cause byte assembly
    always_comb begin
        cause                          = '0;
        cause[CA_LINK]                 = link_q;
        cause[CA_ROLL]                 = roll_q;
        cause[CA_TXERR]                = txerr_q;
        cause[CA_TXEN]                 = tx_en;
        cause[CA_TXOK]                 = txok_q;
        cause[CA_RSN +: RSN_W]         = rsn_q;
    end

    // registered masked interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(status & mask_q);
    end
    assign irq = irq_q;
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
`timescale 1ns/1ps
// mac_irq_ctrl_chk: temporal properties of the interrupt status controller,
// bound to every instance of mac_irq_ctrl.
module mac_irq_ctrl_chk
    import mac_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [RX_SRC-1:0] rx_abort,
    input logic              mgmt_evt,
    input logic              alloc_ok,
    input logic              alloc_fail,
    input logic              roll_evt,
    input logic              txfail_evt,
    input logic              cnt_rd,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [REG_W-1:0]  status,
    input logic [REG_W-1:0]  cause,
    input logic [REG_W-1:0]  mask,
    input logic              irq
);
    assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status[REG_W-1:ST_USED] == '0);

    assert_mgi_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_MGI]) |-> $past(mgmt_evt));

    assert_rxo_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_RXO]) |-> $past(|rx_abort));

    assert_alloc_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fail && !alloc_ok) |=> !status[ST_ALC]);

    assert_roll_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && !roll_evt) |=> !cause[CA_ROLL]);

    assert_txfail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txfail_evt |=> (cause[CA_TXERR] && !cause[CA_TXEN] && !cause[CA_TXOK]));

    assert_irq_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & mask))));

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_evt |=> status[ST_MGI]);

    assert_ack_no_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !mgmt_evt && !status[ST_MGI]) |=> !status[ST_MGI]);
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_abort   (rx_abort),
    .mgmt_evt   (mgmt_evt),
    .alloc_ok   (alloc_ok),
    .alloc_fail (alloc_fail),
    .roll_evt   (roll_evt),
    .txfail_evt (txfail_evt),
    .cnt_rd     (cnt_rd),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .status     (status),
    .cause      (cause),
    .mask       (mask_q),
    .irq        (irq)
);

// File: tb/sim_mac_irq_ctrl.sv
`timescale 1ns/1ps
// sim_mac_irq_ctrl: directed corner cases plus seeded random stimulus,
// compared every cycle against a bench model built from the requirements.
module sim_mac_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_fifo_empty;
    logic [2:0] rx_abort;
    logic       mgmt_evt, alloc_req, alloc_ok, alloc_fail;
    logic       link_evt, roll_evt, tx_ok_evt, txfail_evt;
    logic [1:0] txfail_rsn;
    logic       cnt_rd, reg_wr;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] status, cause;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    logic m_txe, m_alc, m_rxo, m_mgi, m_link, m_roll, m_txerr, m_txen, m_txok;
    logic m_le, m_re, m_te, m_irq;
    logic [1:0] m_rsn;
    logic [7:0] m_mask;

    always #2.5 clk = ~clk;

    mac_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tx_fifo_empty(tx_fifo_empty), .rx_abort(rx_abort),
        .mgmt_evt(mgmt_evt), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
        .alloc_fail(alloc_fail), .link_evt(link_evt), .roll_evt(roll_evt),
        .tx_ok_evt(tx_ok_evt), .txfail_evt(txfail_evt), .txfail_rsn(txfail_rsn),
        .cnt_rd(cnt_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .status(status), .cause(cause), .irq(irq)
    );

    function automatic logic [7:0] exp_status();
        logic phe;
        phe = (m_link & m_le) | (m_roll & m_re) | (m_txerr & m_te);
        return {3'b000, m_mgi, phe, m_rxo, m_alc, m_txe};
    endfunction

    function automatic logic [7:0] exp_cause();
        return {1'b0, m_rsn, m_txok, m_txen, m_txerr, m_roll, m_link};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        rx_abort = '0; mgmt_evt = 0; alloc_req = 0; alloc_ok = 0; alloc_fail = 0;
        link_evt = 0; roll_evt = 0; tx_ok_evt = 0; txfail_evt = 0; txfail_rsn = '0;
        cnt_rd = 0; reg_wr = 0; reg_sel = 2'd3; reg_wdata = '0;
    endtask

    task automatic model_reset();
        {m_txe, m_alc, m_rxo, m_mgi, m_link, m_roll, m_txerr, m_txen, m_txok} = '0;
        {m_le, m_re, m_te, m_irq} = '0;
        m_rsn = '0; m_mask = '0;
    endtask

    task automatic compare_all();
        logic [7:0] es, ec;
        es = exp_status();
        ec = exp_cause();
        check("R2", {5'b0, status[7:5]}, {5'b0, es[7:5]});
        check("R5", {7'b0, status[0]}, {7'b0, es[0]});
        check("R6", {7'b0, status[1]}, {7'b0, es[1]});
        check("R4", {7'b0, status[2]}, {7'b0, es[2]});
        check("R7", {7'b0, status[3]}, {7'b0, es[3]});
        check("R3", {7'b0, status[4]}, {7'b0, es[4]});
        check("R8", {7'b0, cause[0]}, {7'b0, ec[0]});
        check("R9", {7'b0, cause[1]}, {7'b0, ec[1]});
        check("R10", {1'b0, cause[7:2], 1'b0}, {1'b0, ec[7:2], 1'b0});
        check("R11", {7'b0, irq}, {7'b0, m_irq});
    endtask

    // advance one clock with the driven inputs, update the model, check outputs
    task automatic step();
        logic ack, wm, wc;
        logic n_txe, n_alc, n_rxo, n_mgi, n_link, n_roll, n_txerr, n_txen, n_txok, n_irq;
        logic [1:0] n_rsn;
        ack = reg_wr && reg_sel == 2'd0;
        wm  = reg_wr && reg_sel == 2'd1;
        wc  = reg_wr && reg_sel == 2'd2;
        n_irq   = |(exp_status() & m_mask);
        n_txe   = tx_fifo_empty | (m_txe & ~(ack & reg_wdata[0]));
        n_rxo   = (|rx_abort) | (m_rxo & ~(ack & reg_wdata[2]));
        n_mgi   = mgmt_evt | (m_mgi & ~(ack & reg_wdata[4]));
        n_alc   = alloc_ok | (m_alc & ~(alloc_req | alloc_fail));
        n_link  = link_evt | (m_link & ~(wc & ~reg_wdata[0]));
        n_roll  = roll_evt | (m_roll & ~cnt_rd);
        n_txerr = txfail_evt | (m_txerr & ~(wc & reg_wdata[3]));
        n_rsn   = txfail_evt ? txfail_rsn : (n_txerr ? m_rsn : 2'b00);
        n_txen  = txfail_evt ? 1'b0 : (wc ? reg_wdata[3] : m_txen);
        n_txok  = txfail_evt ? 1'b0 : (tx_ok_evt ? 1'b1 : m_txok);
        @(posedge clk);
        m_txe = n_txe; m_rxo = n_rxo; m_mgi = n_mgi; m_alc = n_alc;
        m_link = n_link; m_roll = n_roll; m_txerr = n_txerr; m_rsn = n_rsn;
        m_txen = n_txen; m_txok = n_txok; m_irq = n_irq;
        if (wc) begin m_le = reg_wdata[0]; m_re = reg_wdata[1]; m_te = reg_wdata[2]; end
        if (wm) m_mask = reg_wdata;
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        step();
    endtask

    // watchdog: a hung run is a failure that still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 0; tx_fifo_empty = 0; idle_inputs(); model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", status, 8'h00);
        check("R1", cause, 8'h00);
        check("R1", {7'b0, irq}, 8'h00);

        // R13: acknowledge of all ones on a clear status sets nothing
        wr(2'd0, 8'hFF);
        check("R13", status, 8'h00);
        wr(2'd1, 8'hFF);                         // unmask all for R11

        // R3 and R13: management latch, zero ack ignored, ack clears
        mgmt_evt = 1; step();
        step();
        check("R11", {7'b0, irq}, 8'h01);
        wr(2'd0, 8'h00);
        check("R13", {7'b0, status[4]}, 8'h01);
        wr(2'd0, 8'h10);
        check("R3", {7'b0, status[4]}, 8'h00);

        // R12: event and acknowledge in one clock, event wins
        mgmt_evt = 1; reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'h10; step();
        check("R12", {7'b0, status[4]}, 8'h01);
        wr(2'd0, 8'h10);

        // R4: each abort reason
        for (int i = 0; i < 3; i++) begin
            rx_abort = 3'(1 << i); step();
            check("R4", {7'b0, status[2]}, 8'h01);
            wr(2'd0, 8'h04);
        end

        // R5: ack while still empty keeps the bit, after drain it clears
        tx_fifo_empty = 1; step();
        wr(2'd0, 8'h01);
        check("R5", {7'b0, status[0]}, 8'h01);
        tx_fifo_empty = 0;
        wr(2'd0, 8'h01);
        check("R5", {7'b0, status[0]}, 8'h00);

        // R6: alloc set, ack ignored, cleared by request and by failure
        alloc_ok = 1; step();
        wr(2'd0, 8'h02);
        check("R6", {7'b0, status[1]}, 8'h01);
        alloc_req = 1; step();
        check("R6", {7'b0, status[1]}, 8'h00);
        alloc_ok = 1; step();
        alloc_fail = 1; step();
        check("R6", {7'b0, status[1]}, 8'h00);

        // R7: causes latch with enables off, protocol bit stays low
        link_evt = 1; roll_evt = 1; step();
        check("R7", {7'b0, status[3]}, 8'h00);
        // R8: enable link only, then drop enable to clear
        wr(2'd2, 8'h09);
        check("R7", {7'b0, status[3]}, 8'h01);
        wr(2'd2, 8'h0A);
        check("R8", {7'b0, cause[0]}, 8'h00);
        check("R7", {7'b0, status[3]}, 8'h01);
        // R9: counter read clears rollover
        cnt_rd = 1; step();
        check("R9", {7'b0, cause[1]}, 8'h00);

        // R10: success then fatal error with reason late collision
        wr(2'd2, 8'h0F);
        tx_ok_evt = 1; step();
        check("R10", {7'b0, cause[4]}, 8'h01);
        txfail_evt = 1; txfail_rsn = 2'd2; step();
        check("R10", cause, 8'h44);
        check("R7", {7'b0, status[3]}, 8'h01);
        wr(2'd2, 8'h0F);
        check("R10", cause, 8'h08);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            tx_fifo_empty = ($urandom % 6) == 0;
            rx_abort   = (($urandom % 12) == 0) ? 3'($urandom) : 3'b0;
            mgmt_evt   = ($urandom % 10) == 0;
            alloc_req  = ($urandom % 9) == 0;
            alloc_ok   = ($urandom % 8) == 0;
            alloc_fail = ($urandom % 11) == 0;
            link_evt   = ($urandom % 13) == 0;
            roll_evt   = ($urandom % 13) == 0;
            tx_ok_evt  = ($urandom % 7) == 0;
            txfail_evt = ($urandom % 17) == 0;
            txfail_rsn = 2'($urandom);
            cnt_rd     = ($urandom % 9) == 0;
            reg_wr     = ($urandom % 3) == 0;
            reg_sel    = 2'($urandom);
            reg_wdata  = 8'($urandom);
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule